// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wake Logic

This block is the operating-mode state machine of a system supervisor. It holds one of four modes: Normal Request (`MODE_NREQ`), Normal (`MODE_NORMAL`), Standby (`MODE_STANDBY`) and Stop (`MODE_STOP`). A host drives decoded mode commands through a serial link. The block also watches that link's active-low chip select (`spi_cs_n`).

A Stop command is held pending until the rising edge of chip select that ends the message, so the host can finish its last access before the supply stage sees `stop_o`. Three sources leave Stop, each sending the block to Normal Request:

- a falling edge on chip select;
- an over-current that stays high for a deglitch window;
- an expired watchdog while the watchdog is enabled.

The watchdog case also asserts the reset request. An over-current wake raises a one-cycle interrupt. It then locks out commands for a fixed number of microsecond ticks.

The named transitions are:

- **T_CMD_NORMAL**: Normal Request, Normal or Standby go to Normal.
- **T_CMD_STANDBY**: Normal Request, Normal or Standby go to Standby.
- **T_ARM_STOP**: Normal or Standby set the pending flag.
- **T_ENTER_STOP**: a pending Stop plus a chip-select rise goes to Stop.
- **T_WAKE_CS**, **T_WAKE_OCP** and **T_WAKE_WDG**: Stop goes to Normal Request.

Top module: `lpm_sequencer`

## Requirements
- R1: While reset is applied, and right after it is released, `mode_o` is 0 (Normal Request) and `rst_req_o` is 1. `rst_req_o` falls after RST_CYCLES (default 4) clock edges.
- R2: The mode encoding is 0 Normal Request, 1 Normal, 2 Standby, 3 Stop. On `cmd_mode`, 1 means Normal, 2 Standby, 3 Stop and 0 none. An accepted Normal or Standby command, given in Normal Request, Normal or Standby, moves `mode_o` to that mode at the next clock edge.
- R3: A Stop command in Normal or Standby leaves the mode unchanged. It arms a pending flag. The mode becomes Stop at the edge where `spi_cs_n` is seen rising (low on the previous edge, high now). `stop_o` is 1 exactly when the mode is Stop.
- R4: A Stop command given in Normal Request is rejected, and the mode stays Normal Request.
- R5: In Stop, a falling edge of `spi_cs_n` moves the mode to Normal Request at that clock edge. Mode commands received in Stop are ignored.
- R6: In Stop, `wdg_expired` with `wdg_en`=1 moves the mode to Normal Request and sets `rst_req_o` for RST_CYCLES edges. With `wdg_en`=0 the expiry is ignored.
- R7: In Stop, `ocp_in` wakes the block only after it has stayed high across DEGLITCH_TICKS (default 40) consecutive `tick_us` pulses. Any drop of `ocp_in` clears the count.
- R8: An over-current wake sets `irq_o` for exactly one cycle, in the same cycle that the mode becomes Normal Request.
- R9: After an over-current wake, commands and chip-select edges are ignored until LOCKOUT_TICKS (default 20) `tick_us` pulses have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_mode | input | 2 | Requested mode: 1 Normal, 2 Standby, 3 Stop |
| spi_cs_n | input | 1 | Serial link chip select, active low |
| ocp_in | input | 1 | Supply over-current indication |
| wdg_en | input | 1 | Watchdog enable |
| wdg_expired | input | 1 | Watchdog period elapsed |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| mode_o | output | 2 | Current mode |
| stop_o | output | 1 | Stop flag for the supply stage |
| rst_req_o | output | 1 | Reset request |
| irq_o | output | 1 | Over-current wake interrupt pulse |

## Verification
Every result is registered once:

- `mode_o`, `stop_o` and `irq_o` change at the first clock edge after the inputs that cause them.
- `rst_req_o` rises at that same edge and then holds for RST_CYCLES edges.
- The over-current wake lands at the edge that carries the last deglitch tick.

The bench drives inputs at the falling edge and samples one full cycle later, at the next falling edge, so each check falls after exactly one register stage. The tests around the tick counts check the cycle just before each limit and the cycle that reaches it. This covers both the 39-tick and 40-tick over-current windows and the last locked and first unlocked command.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_NREQ    = 2'd0,
        MODE_NORMAL  = 2'd1,
        MODE_STANDBY = 2'd2,
        MODE_STOP    = 2'd3
    } mode_t;

    localparam logic [1:0] CMD_NORMAL  = 2'd1;
    localparam logic [1:0] CMD_STANDBY = 2'd2;
    localparam logic [1:0] CMD_STOP    = 2'd3;

endpackage

// File: rtl/lpm_cs_edges.sv
module lpm_cs_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= cs_n;
    end

    assign rise = !prev_q && cs_n;
    assign fall = prev_q && !cs_n;

    assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/lpm_tick_filter.sv
module lpm_tick_filter #(
    parameter int TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic tick,
    output logic fire
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign fire = level && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!level)     cnt_q <= '0;
        else if (fire)       cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_clears_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !level |=> cnt_q == '0);
endmodule

// File: rtl/lpm_tick_timer.sv
module lpm_tick_timer #(
    parameter int TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic busy
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= CW'(TICKS);
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_load_locks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/lpm_reset_stretch.sv
module lpm_reset_stretch #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic req
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= CW'(CYCLES);
        else if (trigger)        cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign req = (cnt_q != '0);

    assert_trigger_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> req);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int DEGLITCH_TICKS = 40,
    parameter int LOCKOUT_TICKS  = 20,
    parameter int RST_CYCLES     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_mode,
    input  logic       spi_cs_n,
    input  logic       ocp_in,
    input  logic       wdg_en,
    input  logic       wdg_expired,
    input  logic       tick_us,
    output logic [1:0] mode_o,
    output logic       stop_o,
    output logic       rst_req_o,
    output logic       irq_o
);
    mode_t state_q, state_d;
    logic  pend_q, pend_d;
    logic  stop_q, irq_q;

    logic cs_rise, cs_fall;
    logic ocp_fire;
    logic locked;
    logic cmd_ok, cs_rise_ok, cs_fall_ok;
    logic in_stop;
    logic wake_wdg, wake_ocp, wake_cs;

    assign in_stop = (state_q == MODE_STOP);

    lpm_cs_edges u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (spi_cs_n),
        .rise  (cs_rise),
        .fall  (cs_fall)
    );

    lpm_tick_filter #(.TICKS(DEGLITCH_TICKS)) u_ocp_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ocp_in && in_stop),
        .tick  (tick_us),
        .fire  (ocp_fire)
    );

    lpm_tick_timer #(.TICKS(LOCKOUT_TICKS)) u_lockout (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_ocp),
        .tick  (tick_us),
        .busy  (locked)
    );

    lpm_reset_stretch #(.CYCLES(RST_CYCLES)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (wake_wdg),
        .req     (rst_req_o)
    );

    assign cmd_ok     = cmd_valid && !locked;
    assign cs_rise_ok = cs_rise && !locked;
    assign cs_fall_ok = cs_fall && !locked;

    assign wake_wdg = in_stop && wdg_en && wdg_expired;
    assign wake_ocp = in_stop && !wake_wdg && ocp_fire;
    assign wake_cs  = in_stop && !wake_wdg && !ocp_fire && cs_fall_ok;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            MODE_NREQ: begin
                pend_d = 1'b0;
                if (cmd_ok && cmd_mode == CMD_NORMAL)       state_d = MODE_NORMAL;
                else if (cmd_ok && cmd_mode == CMD_STANDBY) state_d = MODE_STANDBY;
            end
            MODE_NORMAL, MODE_STANDBY: begin
                if (cmd_ok && cmd_mode == CMD_NORMAL) begin
                    state_d = MODE_NORMAL;
                    pend_d  = 1'b0;
                end else if (cmd_ok && cmd_mode == CMD_STANDBY) begin
                    state_d = MODE_STANDBY;
                    pend_d  = 1'b0;
                end else if (pend_q && cs_rise_ok) begin
                    state_d = MODE_STOP;
                    pend_d  = 1'b0;
                end else if (cmd_ok && cmd_mode == CMD_STOP) begin
                    pend_d  = 1'b1;
                end
            end
            MODE_STOP: begin
                pend_d = 1'b0;
                if (wake_wdg || wake_ocp || wake_cs) state_d = MODE_NREQ;
            end
            default: begin
                state_d = MODE_NREQ;
                pend_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_NREQ;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            stop_q <= (state_d == MODE_STOP);
            irq_q  <= wake_ocp;
        end
    end

    assign mode_o = state_q;
    assign stop_o = stop_q;
    assign irq_o  = irq_q;

    assert_stop_flag_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o == (mode_o == MODE_STOP));

    assert_stop_only_on_cs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_STOP && state_d == MODE_STOP) |-> cs_rise);

    assert_no_stop_from_nreq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == MODE_NREQ |=> state_q != MODE_STOP);

    assert_wdg_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && wdg_en && wdg_expired) |=> (state_q == MODE_NREQ && rst_req_o));

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_lockout_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && state_q == MODE_NREQ) |=> state_q == MODE_NREQ);
endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_mode = 2'd0;
    logic       spi_cs_n = 1'b1;
    logic       ocp_in = 1'b0;
    logic       wdg_en = 1'b0;
    logic       wdg_expired = 1'b0;
    logic       tick_us = 1'b0;
    logic [1:0] mode_o;
    logic       stop_o, rst_req_o, irq_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    lpm_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .spi_cs_n(spi_cs_n), .ocp_in(ocp_in), .wdg_en(wdg_en),
        .wdg_expired(wdg_expired), .tick_us(tick_us), .mode_o(mode_o),
        .stop_o(stop_o), .rst_req_o(rst_req_o), .irq_o(irq_o)
    );

    // [9] cmd_valid [8:7] cmd [6] cs_n [5] wdg_en [4] wdg_expired
    // [3:2] expected mode [1] expected stop [0] expected reset request
    localparam int NV = 20;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_11_1_0_0_00_0_0, // R4 stop rejected in NREQ
        10'b1_01_1_0_0_01_0_0, // R2 normal
        10'b1_10_1_0_0_10_0_0, // R2 standby
        10'b1_01_0_0_0_01_0_0, // R2 normal, cs falls
        10'b1_11_0_0_0_01_0_0, // R3 stop armed
        10'b0_00_0_0_0_01_0_0, // R3 still waiting
        10'b0_00_1_0_0_11_1_0, // R3 cs rise enters stop
        10'b0_00_1_0_0_11_1_0,
        10'b1_01_1_0_0_11_1_0, // R5 command ignored in stop
        10'b0_00_0_0_0_00_0_0, // R5 cs wake
        10'b0_00_1_0_0_00_0_0,
        10'b1_10_1_0_0_10_0_0,
        10'b1_11_0_0_0_10_0_0,
        10'b0_00_1_0_0_11_1_0,
        10'b0_00_1_0_1_11_1_0, // R6 disabled watchdog ignored
        10'b0_00_1_1_1_00_0_1, // R6 watchdog wake with reset
        10'b0_00_1_0_0_00_0_1,
        10'b0_00_1_0_0_00_0_1,
        10'b0_00_1_0_0_00_0_1,
        10'b0_00_1_0_0_00_0_0
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic cv, input logic [1:0] cm, input logic cs,
                        input logic oc, input logic tk);
        cmd_valid = cv; cmd_mode = cm; spi_cs_n = cs; ocp_in = oc; tick_us = tk;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; tick_us = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mode", {2'b0, mode_o}, 4'd0);
        chk("R1 reset request", {3'b0, rst_req_o}, 4'd1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 request held", {3'b0, rst_req_o}, 4'd1);
        @(negedge clk);
        chk("R1 request released", {3'b0, rst_req_o}, 4'd0);

        for (int i = 0; i < NV; i++) begin
            wdg_en = VEC[i][5]; wdg_expired = VEC[i][4];
            step(VEC[i][9], VEC[i][8:7], VEC[i][6], 1'b0, 1'b0);
            chk($sformatf("R2-table vec%0d mode", i), {2'b0, mode_o}, {2'b0, VEC[i][3:2]});
            chk($sformatf("R3 vec%0d stop", i), {3'b0, stop_o}, {3'b0, VEC[i][1]});
            chk($sformatf("R6 vec%0d rst", i), {3'b0, rst_req_o}, {3'b0, VEC[i][0]});
        end
        wdg_en = 1'b0; wdg_expired = 1'b0;

        // enter stop for the over-current tests
        step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        chk("R3 stop entered", {2'b0, mode_o}, 4'd3);

        // R7: 39 ticks then a drop: glitch ignored
        for (int k = 0; k < 39; k++) step(1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        chk("R7 short glitch ignored", {2'b0, mode_o}, 4'd3);
        for (int k = 0; k < 39; k++) step(1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        chk("R7 39 ticks no wake", {2'b0, mode_o}, 4'd3);
        chk("R8 no irq yet", {3'b0, irq_o}, 4'd0);
        step(1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        chk("R7 40th tick wakes", {2'b0, mode_o}, 4'd0);
        chk("R8 irq raised", {3'b0, irq_o}, 4'd1);
        step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        chk("R8 irq one cycle", {3'b0, irq_o}, 4'd0);

        // R9: lockout of 20 ticks
        step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R9 command locked", {2'b0, mode_o}, 4'd0);
        for (int k = 0; k < 19; k++) step(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R9 still locked at 19", {2'b0, mode_o}, 4'd0);
        step(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R9 unlocked after 20", {2'b0, mode_o}, 4'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule